// File: doc/BRIEF.md
# Segmented DMA Transfer Buffer Controller

This block sits behind the byte interface of a half-duplex SPI slave front end and keeps track of the two streaming buffers that the master reaches through the DMA read and DMA write commands. The local side either loads a read buffer with a declared length or arms a write buffer with a maximum length. The master then reads or writes that buffer in as many short segments as it likes. Each segment is its own chip-select transaction, and the byte position carries on from one segment to the next. The buffer stays live until the master sends the matching termination opcode.

The controller holds no data. It turns the running position into a local byte address. Read bytes pass from the local memory to the front end, and write bytes pass from the front end to the local memory, gated so that nothing outside the buffer's length is touched. Bytes read past the end, or read while no buffer is loaded, come back as a fixed filler value. Bytes written past the end are dropped. A sticky flag records each overrun. On termination the block pulses a done strobe with the number of bytes actually moved and marks the buffer empty, ready for the next load or arm.

Top module: `seg_dma_buf_ctrl`

## Requirements
- R1: After reset both buffers are empty, both overrun flags and both done strobes are low, no transfer is active, and fe_rd_data shows the filler value FILL (default 8'hFF).
- R2: A command with low nibble 4 selects a DMA read, and one with low nibble 3 selects a DMA write, when the high nibble is one of the lane codes 0x0, 0x1, 0x2, 0x5, 0xA. Any other command, including one with a different high nibble, leaves byte strobes without effect on the position.
- R3: During a DMA read, while the read buffer is loaded and its position is below its length, lcl_rd_addr equals the position, fe_rd_data equals lcl_rd_data in the same cycle, and each fe_rd_stb advances the position by one.
- R4: The read and write positions are kept across chip-select ends and new commands. A segment starts where the previous segment of the same buffer stopped.
- R5: A read strobe while the read buffer is loaded and its position equals its length returns FILL, leaves the position unchanged and sets rd_overrun. A final segment may be shorter than, equal to or longer than the remaining bytes.
- R6: During a DMA write into an armed buffer with its position below its length, each fe_wr_stb raises lcl_wr_en in the same cycle with lcl_wr_addr equal to the position and lcl_wr_data equal to fe_wr_data. Once the position reaches the length, further write bytes are discarded (lcl_wr_en stays low) and wr_overflow is set.
- R7: Opcode 0x08 retires the read buffer and opcode 0x07 retires the write buffer. One cycle later the matching done output is high for one cycle and the matching count holds the number of bytes transferred. The position is zeroed and the buffer is marked empty. A termination with no buffer loaded reports a count of 0.
- R8: lcl_rd_load and lcl_wr_arm are accepted only while the matching buffer is empty. An accepted load clears that buffer's overrun flag. A load offered while the buffer is full is ignored.
- R9: With no read buffer loaded, read strobes return FILL and leave both the position and rd_overrun unchanged. With no write buffer armed, write strobes produce no lcl_wr_en and leave wr_overflow unchanged.
- R10: fe_cs_end without a command in the same cycle ends the active transfer. Byte strobes after it have no effect until the next read or write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fe_cmd_vld | input | 1 | Front end has received a command byte |
| fe_cmd | input | 8 | Command opcode |
| fe_cs_end | input | 1 | Chip select released, transaction over |
| fe_rd_stb | input | 1 | Master consumes one read byte |
| fe_rd_data | output | 8 | Byte handed to the front end for the master |
| fe_wr_stb | input | 1 | Master supplies one write byte |
| fe_wr_data | input | 8 | Write byte from the master |
| lcl_rd_load | input | 1 | Local side loads a read buffer |
| lcl_rd_len | input | LEN_W | Length of the read buffer being loaded |
| lcl_rd_addr | output | LEN_W | Local read address (current read position) |
| lcl_rd_data | input | 8 | Local byte at lcl_rd_addr |
| lcl_wr_arm | input | 1 | Local side arms a write buffer |
| lcl_wr_len | input | LEN_W | Maximum length of the write buffer |
| lcl_wr_en | output | 1 | Write one byte into local memory |
| lcl_wr_addr | output | LEN_W | Local write address |
| lcl_wr_data | output | 8 | Local write byte |
| rd_loaded | output | 1 | A read buffer is loaded |
| wr_armed | output | 1 | A write buffer is armed |
| rd_overrun | output | 1 | A read went past the loaded length |
| wr_overflow | output | 1 | A write byte past the armed length was dropped |
| rd_done | output | 1 | One-cycle pulse, read buffer retired |
| rd_count | output | LEN_W | Bytes read from the retired buffer |
| wr_done | output | 1 | One-cycle pulse, write buffer retired |
| wr_count | output | LEN_W | Bytes written into the retired buffer |

## Verification
The bench builds the block with the default LEN_W of 13 and the default filler 8'hFF. That makes a 4092-byte read buffer reachable, so it can be drained by eight 512-byte segments, with the eighth segment ending in four filler bytes and a set overrun flag. Small lengths in the same build cover the short final segment, write overflow inside a segment, rejected reloads while full, and termination with nothing loaded. All five lane-code prefixes are used on the read and write commands.

// File: rtl/seg_dma_pkg.sv
package seg_dma_pkg;

    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2
    } xfer_e;

    localparam logic [7:0] OP_RD_RETIRE = 8'h08;
    localparam logic [7:0] OP_WR_RETIRE = 8'h07;
    localparam logic [3:0] OP_RD_BASE   = 4'h4;
    localparam logic [3:0] OP_WR_BASE   = 4'h3;

    // Upper-nibble lane codes allowed on streaming commands.
    function automatic logic lane_code_ok(input logic [3:0] hi);
        return (hi == 4'h0) || (hi == 4'h1) || (hi == 4'h2) ||
               (hi == 4'h5) || (hi == 4'hA);
    endfunction

    function automatic xfer_e decode_xfer(input logic [7:0] op);
        xfer_e k;
        k = XFER_NONE;
        if (lane_code_ok(op[7:4])) begin
            if (op[3:0] == OP_RD_BASE)      k = XFER_READ;
            else if (op[3:0] == OP_WR_BASE) k = XFER_WRITE;
        end
        return k;
    endfunction

endpackage

// File: rtl/seg_dma_cmd.sv
module seg_dma_cmd
    import seg_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_vld,
    input  logic [7:0] cmd,
    input  logic       cs_end,
    output xfer_e      act,
    output logic       rd_retire,
    output logic       wr_retire
);

    typedef struct packed {
        xfer_e act;
    } cmd_state_t;

    cmd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cmd_vld)     s_d.act = decode_xfer(cmd);
        else if (cs_end) s_d.act = XFER_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{act: XFER_NONE};
        else        s_q <= s_d;
    end

    assign act       = s_q.act;
    assign rd_retire = cmd_vld && (cmd == OP_RD_RETIRE);
    assign wr_retire = cmd_vld && (cmd == OP_WR_RETIRE);

    assert_cs_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_end && !cmd_vld) |=> (act == XFER_NONE));

    assert_act_from_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((act != XFER_NONE) && !$stable(act)) |-> $past(cmd_vld));

endmodule

// File: rtl/seg_dma_chan.sv
module seg_dma_chan #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             stb,
    output logic [LEN_W-1:0] pos,
    output logic             loaded,
    output logic             in_range,
    output logic             ovr_flag,
    output logic             done,
    output logic [LEN_W-1:0] count
);

    typedef struct packed {
        logic             loaded;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] pos;
        logic             flag;
        logic             done;
        logic [LEN_W-1:0] count;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        avail;

    assign avail = s_q.loaded && (s_q.pos < s_q.len);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (retire) begin
            s_d.done   = 1'b1;
            s_d.count  = s_q.pos;
            s_d.pos    = '0;
            s_d.loaded = 1'b0;
        end else if (load && !s_q.loaded) begin
            s_d.loaded = 1'b1;
            s_d.len    = load_len;
            s_d.pos    = '0;
            s_d.flag   = 1'b0;
        end else if (stb) begin
            if (avail)            s_d.pos  = s_q.pos + LEN_W'(1);
            else if (s_q.loaded)  s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos      = s_q.pos;
    assign loaded   = s_q.loaded;
    assign in_range = avail;
    assign ovr_flag = s_q.flag;
    assign done     = s_q.done;
    assign count    = s_q.count;

    assert_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.loaded |-> (s_q.pos <= s_q.len));

    assert_retire_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (!s_q.loaded && (s_q.pos == '0) && s_q.done));

    assert_busy_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && s_q.loaded && !retire) |=> $stable(s_q.len));

    assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(stb && s_q.loaded && !avail));

    assert_unloaded_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !s_q.loaded && !retire && !load) |=> ($stable(s_q.pos) && $stable(s_q.flag)));

endmodule

// File: rtl/seg_dma_buf_ctrl.sv
module seg_dma_buf_ctrl
    import seg_dma_pkg::*;
#(
    parameter int         LEN_W = 13,
    parameter logic [7:0] FILL  = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fe_cmd_vld,
    input  logic [7:0]       fe_cmd,
    input  logic             fe_cs_end,
    input  logic             fe_rd_stb,
    output logic [7:0]       fe_rd_data,
    input  logic             fe_wr_stb,
    input  logic [7:0]       fe_wr_data,
    input  logic             lcl_rd_load,
    input  logic [LEN_W-1:0] lcl_rd_len,
    output logic [LEN_W-1:0] lcl_rd_addr,
    input  logic [7:0]       lcl_rd_data,
    input  logic             lcl_wr_arm,
    input  logic [LEN_W-1:0] lcl_wr_len,
    output logic             lcl_wr_en,
    output logic [LEN_W-1:0] lcl_wr_addr,
    output logic [7:0]       lcl_wr_data,
    output logic             rd_loaded,
    output logic             wr_armed,
    output logic             rd_overrun,
    output logic             wr_overflow,
    output logic             rd_done,
    output logic [LEN_W-1:0] rd_count,
    output logic             wr_done,
    output logic [LEN_W-1:0] wr_count
);

    localparam int N_CH  = 2;
    localparam int CH_RD = 0;
    localparam int CH_WR = 1;

    xfer_e act;
    logic  rd_retire, wr_retire;

    logic [N_CH-1:0]  retire_v, load_v, stb_v;
    logic [LEN_W-1:0] len_v   [N_CH];
    logic [LEN_W-1:0] pos_v   [N_CH];
    logic [LEN_W-1:0] cnt_v   [N_CH];
    logic [N_CH-1:0]  loaded_v, inrng_v, flag_v, done_v;

    seg_dma_cmd i_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (fe_cmd_vld),
        .cmd       (fe_cmd),
        .cs_end    (fe_cs_end),
        .act       (act),
        .rd_retire (rd_retire),
        .wr_retire (wr_retire)
    );

    always_comb begin
        retire_v[CH_RD] = rd_retire;
        retire_v[CH_WR] = wr_retire;
        load_v[CH_RD]   = lcl_rd_load;
        load_v[CH_WR]   = lcl_wr_arm;
        len_v[CH_RD]    = lcl_rd_len;
        len_v[CH_WR]    = lcl_wr_len;
        stb_v[CH_RD]    = fe_rd_stb && (act == XFER_READ);
        stb_v[CH_WR]    = fe_wr_stb && (act == XFER_WRITE);
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        seg_dma_chan #(.LEN_W(LEN_W)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .retire   (retire_v[g]),
            .load     (load_v[g]),
            .load_len (len_v[g]),
            .stb      (stb_v[g]),
            .pos      (pos_v[g]),
            .loaded   (loaded_v[g]),
            .in_range (inrng_v[g]),
            .ovr_flag (flag_v[g]),
            .done     (done_v[g]),
            .count    (cnt_v[g])
        );
    end

    assign fe_rd_data  = ((act == XFER_READ) && inrng_v[CH_RD]) ? lcl_rd_data : FILL;
    assign lcl_rd_addr = pos_v[CH_RD];

    assign lcl_wr_en   = stb_v[CH_WR] && inrng_v[CH_WR];
    assign lcl_wr_addr = pos_v[CH_WR];
    assign lcl_wr_data = fe_wr_data;

    assign rd_loaded   = loaded_v[CH_RD];
    assign wr_armed    = loaded_v[CH_WR];
    assign rd_overrun  = flag_v[CH_RD];
    assign wr_overflow = flag_v[CH_WR];
    assign rd_done     = done_v[CH_RD];
    assign wr_done     = done_v[CH_WR];
    assign rd_count    = cnt_v[CH_RD];
    assign wr_count    = cnt_v[CH_WR];

    assert_wr_en_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_wr_en |-> (wr_armed && fe_wr_stb));

    assert_rd_retire_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_cmd_vld && (fe_cmd == OP_RD_RETIRE)) |=> (rd_done && !rd_loaded));

    assert_wr_retire_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_cmd_vld && (fe_cmd == OP_WR_RETIRE)) |=> (wr_done && !wr_armed));

    assert_filler_unloaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_loaded |-> (fe_rd_data == FILL));

endmodule

// File: tb/test_seg_dma_buf_ctrl.sv
module test_seg_dma_buf_ctrl;

    localparam int         LEN_W = 13;
    localparam logic [7:0] FILL  = 8'hFF;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fe_cmd_vld, fe_cs_end, fe_rd_stb, fe_wr_stb;
    logic [7:0]       fe_cmd, fe_wr_data, fe_rd_data, lcl_rd_data, lcl_wr_data;
    logic             lcl_rd_load, lcl_wr_arm, lcl_wr_en;
    logic [LEN_W-1:0] lcl_rd_len, lcl_wr_len, lcl_rd_addr, lcl_wr_addr;
    logic             rd_loaded, wr_armed, rd_overrun, wr_overflow, rd_done, wr_done;
    logic [LEN_W-1:0] rd_count, wr_count;

    int n_chk = 0;
    int n_err = 0;

    // reference model state: channel 0 read, channel 1 write
    int m_act = 0;
    bit m_ld   [2];
    int m_len  [2];
    int m_pos  [2];
    bit m_flag [2];
    bit m_done [2];
    int m_cnt  [2];

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    assign lcl_rd_data = pat(int'(lcl_rd_addr));

    seg_dma_buf_ctrl #(.LEN_W(LEN_W), .FILL(FILL)) i_seg_dma_buf_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fe_cmd_vld(fe_cmd_vld), .fe_cmd(fe_cmd), .fe_cs_end(fe_cs_end),
        .fe_rd_stb(fe_rd_stb), .fe_rd_data(fe_rd_data),
        .fe_wr_stb(fe_wr_stb), .fe_wr_data(fe_wr_data),
        .lcl_rd_load(lcl_rd_load), .lcl_rd_len(lcl_rd_len),
        .lcl_rd_addr(lcl_rd_addr), .lcl_rd_data(lcl_rd_data),
        .lcl_wr_arm(lcl_wr_arm), .lcl_wr_len(lcl_wr_len),
        .lcl_wr_en(lcl_wr_en), .lcl_wr_addr(lcl_wr_addr), .lcl_wr_data(lcl_wr_data),
        .rd_loaded(rd_loaded), .wr_armed(wr_armed),
        .rd_overrun(rd_overrun), .wr_overflow(wr_overflow),
        .rd_done(rd_done), .rd_count(rd_count),
        .wr_done(wr_done), .wr_count(wr_count)
    );

    task automatic chk(input string req, input string what, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    function automatic int mdl_kind(input logic [7:0] c);
        bit lane_ok;
        lane_ok = (c[7:4] == 4'h0) || (c[7:4] == 4'h1) || (c[7:4] == 4'h2) ||
                  (c[7:4] == 4'h5) || (c[7:4] == 4'hA);
        if (lane_ok && c[3:0] == 4'h4) return 1;
        if (lane_ok && c[3:0] == 4'h3) return 2;
        return 0;
    endfunction

    task automatic mdl_chan(input int c, input bit ret, input bit ld, input int len, input bit stb);
        m_done[c] = 1'b0;
        if (ret) begin
            m_done[c] = 1'b1;
            m_cnt[c]  = m_pos[c];
            m_pos[c]  = 0;
            m_ld[c]   = 1'b0;
        end else if (ld && !m_ld[c]) begin
            m_ld[c]   = 1'b1;
            m_len[c]  = len;
            m_pos[c]  = 0;
            m_flag[c] = 1'b0;
        end else if (stb) begin
            if (m_ld[c] && m_pos[c] < m_len[c]) m_pos[c]++;
            else if (m_ld[c])                   m_flag[c] = 1'b1;
        end
    endtask

    // one clock: compare combinational outputs, advance model, compare registers
    task automatic tick();
        bit in_rd, in_wr, wen;
        int exp_rd;
        #1;
        in_rd  = m_ld[0] && (m_pos[0] < m_len[0]);
        in_wr  = m_ld[1] && (m_pos[1] < m_len[1]);
        exp_rd = (m_act == 1 && in_rd) ? int'(pat(m_pos[0])) : int'(FILL);
        chk("R3", "fe_rd_data", fe_rd_data, exp_rd);
        chk("R3", "lcl_rd_addr", lcl_rd_addr, m_pos[0]);
        wen = fe_wr_stb && (m_act == 2) && in_wr;
        chk("R6", "lcl_wr_en", lcl_wr_en, wen);
        if (wen) begin
            chk("R6", "lcl_wr_addr", lcl_wr_addr, m_pos[1]);
            chk("R6", "lcl_wr_data", lcl_wr_data, fe_wr_data);
        end
        mdl_chan(0, fe_cmd_vld && fe_cmd == 8'h08, lcl_rd_load, int'(lcl_rd_len),
                 fe_rd_stb && m_act == 1);
        mdl_chan(1, fe_cmd_vld && fe_cmd == 8'h07, lcl_wr_arm, int'(lcl_wr_len),
                 fe_wr_stb && m_act == 2);
        if (fe_cmd_vld)     m_act = mdl_kind(fe_cmd);
        else if (fe_cs_end) m_act = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "rd_loaded", rd_loaded, m_ld[0]);
        chk("R8", "wr_armed", wr_armed, m_ld[1]);
        chk("R5", "rd_overrun", rd_overrun, m_flag[0]);
        chk("R6", "wr_overflow", wr_overflow, m_flag[1]);
        chk("R7", "rd_done", rd_done, m_done[0]);
        chk("R7", "wr_done", wr_done, m_done[1]);
        chk("R7", "rd_count", rd_count, m_cnt[0]);
        chk("R7", "wr_count", wr_count, m_cnt[1]);
    endtask

    task automatic do_cmd(input logic [7:0] c);
        fe_cmd_vld = 1'b1; fe_cmd = c; tick(); fe_cmd_vld = 1'b0;
    endtask

    task automatic cs_end();
        fe_cs_end = 1'b1; tick(); fe_cs_end = 1'b0;
    endtask

    task automatic rd_n(input int n);
        fe_rd_stb = 1'b1;
        repeat (n) tick();
        fe_rd_stb = 1'b0;
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) begin
            fe_wr_stb = 1'b1; fe_wr_data = 8'(8'h30 + i * 5); tick();
        end
        fe_wr_stb = 1'b0;
    endtask

    task automatic load_rd(input int len);
        lcl_rd_load = 1'b1; lcl_rd_len = LEN_W'(len); tick(); lcl_rd_load = 1'b0;
    endtask

    task automatic arm_wr(input int len);
        lcl_wr_arm = 1'b1; lcl_wr_len = LEN_W'(len); tick(); lcl_wr_arm = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] lanes [5];
        lanes = '{8'h00, 8'h10, 8'h50, 8'h20, 8'hA0};
        rst_n = 1'b0;
        fe_cmd_vld = 0; fe_cmd = 0; fe_cs_end = 0; fe_rd_stb = 0; fe_wr_stb = 0;
        fe_wr_data = 0; lcl_rd_load = 0; lcl_rd_len = 0; lcl_wr_arm = 0; lcl_wr_len = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "rd_loaded", rd_loaded, 0);
        chk("R1", "wr_armed", wr_armed, 0);
        chk("R1", "rd_overrun", rd_overrun, 0);
        chk("R1", "wr_overflow", wr_overflow, 0);
        chk("R1", "rd_done", rd_done, 0);
        chk("R1", "wr_done", wr_done, 0);
        chk("R1", "fe_rd_data", fe_rd_data, FILL);
        @(negedge clk);

        // R9 reads with nothing loaded
        do_cmd(8'h04); rd_n(3);
        chk("R9", "lcl_rd_addr", lcl_rd_addr, 0);
        chk("R9", "rd_overrun", rd_overrun, 0);
        cs_end();

        // R4/R5 4092-byte buffer drained in eight 512-byte segments
        load_rd(4092);
        for (int k = 0; k < 8; k++) begin
            do_cmd(lanes[k % 5] | 8'h04);
            chk("R4", "segment start addr", lcl_rd_addr, (512 * k < 4092) ? 512 * k : 4092);
            rd_n(512);
            cs_end();
        end
        chk("R5", "rd_overrun after last segment", rd_overrun, 1);
        chk("R5", "position held at length", lcl_rd_addr, 4092);

        // R8 reload while full is ignored
        load_rd(10);
        chk("R8", "rd_loaded kept", rd_loaded, 1);
        do_cmd(8'h54); rd_n(1);
        chk("R8", "old buffer still exhausted", rd_overrun, 1);
        cs_end();

        // R7 retire the read buffer
        do_cmd(8'h08);
        chk("R7", "rd_done", rd_done, 1);
        chk("R7", "rd_count", rd_count, 4092);
        chk("R7", "rd_loaded", rd_loaded, 0);
        tick();
        chk("R7", "rd_done single pulse", rd_done, 0);

        load_rd(5);
        chk("R8", "overrun cleared on load", rd_overrun, 0);
        chk("R8", "rd_loaded", rd_loaded, 1);

        // R2 non-streaming and bad-lane commands
        do_cmd(8'h02); rd_n(2);
        chk("R2", "RDBUF-like opcode ignored", lcl_rd_addr, 0);
        do_cmd(8'h34); rd_n(2);
        chk("R2", "bad lane code ignored", lcl_rd_addr, 0);
        do_cmd(8'h54); rd_n(2);
        chk("R2", "dual lane read accepted", lcl_rd_addr, 2);
        cs_end(); rd_n(2);
        chk("R10", "strobes after cs end", lcl_rd_addr, 2);
        do_cmd(8'h24); rd_n(1); cs_end();
        do_cmd(8'h08);
        chk("R7", "short final segment count", rd_count, 3);

        // R9 writes with nothing armed
        do_cmd(8'h03); wr_n(2);
        chk("R9", "wr_overflow", wr_overflow, 0);
        cs_end();

        // R6 writes in two segments with overflow
        arm_wr(6);
        do_cmd(8'hA3); wr_n(4); cs_end();
        do_cmd(8'h13); wr_n(4);
        chk("R6", "wr_overflow", wr_overflow, 1);
        chk("R4", "write position kept", lcl_wr_addr, 6);
        cs_end();
        arm_wr(2);
        chk("R8", "wr_armed kept", wr_armed, 1);
        do_cmd(8'h07);
        chk("R7", "wr_done", wr_done, 1);
        chk("R7", "wr_count", wr_count, 6);
        arm_wr(3);
        chk("R8", "overflow cleared on arm", wr_overflow, 0);
        do_cmd(8'h53); wr_n(3); cs_end();
        do_cmd(8'h07);
        chk("R7", "wr_count exact fill", wr_count, 3);
        chk("R6", "no overflow at exact fill", wr_overflow, 0);

        // R7 retire with nothing loaded
        do_cmd(8'h08);
        chk("R7", "empty retire done", rd_done, 1);
        chk("R7", "empty retire count", rd_count, 0);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule